// File: doc/BRIEF.md
# Wave Program Counter and Branch Unit

This block holds the 48-bit program counter of a single shader wave and works out the address of the next instruction to fetch. When a wave is launched it takes a start address. From then on it accepts at most one decoded scalar control-flow operation per clock: a plain advance to the next instruction, an unconditional or flag-conditional relative branch, a read of the PC into a 64-bit scalar register pair, a write of the PC from such a pair, or both at once (a swap). Every instruction is taken to be 4 bytes long.

All results that depend on the PC use the address of the instruction that follows the operation, not the operation's own address. Branch targets are formed from that address plus a sign-extended, word-scaled offset. The two lowest PC bits are cleared on every write. The control part is a two-state machine. `ST_IDLE` means no wave has been launched yet, and `ST_RUN` means a wave is executing. The transition `LAUNCH` (from either state into `ST_RUN`) is the only one, and it is taken whenever the launch input is high. Operations presented in `ST_IDLE` are dropped.

Top module: `wave_pc_unit`

## Requirements
- R1: After reset the fetch address is 0, the write-back valid flag is 0, and the unit is in `ST_IDLE`. In that state, operations with `op_valid_i` high leave the fetch address unchanged and produce no write-back.
- R2: With `launch_i` high, the next clock loads the fetch address with `launch_pc_i` with bits [1:0] cleared and enters `ST_RUN`. Launch takes priority over an operation presented in the same cycle.
- R3: In `ST_RUN`, a cycle with `op_valid_i` low leaves the fetch address unchanged and gives no write-back in the next cycle.
- R4: Op code 0 (advance) moves the fetch address to PC+4 on the next clock. Unused op codes 11 to 15 act the same way. All PC sums wrap modulo 2^48.
- R5: Op code 1 (unconditional branch) loads PC+4+sext(imm_i)*4, where imm_i is a 16-bit two's-complement offset.
- R6: Op codes 2..7 branch as in R5 when, respectively, scc_i=1, scc_i=0, vccz_i=1, vccz_i=0, execz_i=1 or execz_i=0. Otherwise they load PC+4.
- R7: Op code 8 (read PC) advances the PC to PC+4. On the next clock it presents wb_data_o = zero-extended PC+4, with wb_valid_o high for exactly that one cycle.
- R8: Op code 9 (write PC) loads sgpr_pair_i[47:0] with bits [1:0] cleared and produces no write-back.
- R9: Op code 10 (swap) loads the PC as in R8. On the same clock it presents the zero-extended old PC+4 on the write-back port with wb_valid_o high.
- R10: fetch_pc_o[1:0] is 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_i | input | 1 | Wave creation strobe |
| launch_pc_i | input | 48 | Address of the wave's first instruction |
| op_valid_i | input | 1 | A control-flow operation is presented this cycle |
| op_i | input | 4 | Operation code (see R4 to R9) |
| imm_i | input | 16 | Signed branch offset in instructions |
| sgpr_pair_i | input | 64 | Source register pair for write PC and swap |
| scc_i | input | 1 | Scalar condition code |
| vccz_i | input | 1 | Vector condition code is zero |
| execz_i | input | 1 | Execute mask is zero |
| fetch_pc_o | output | 48 | Current PC, the address to fetch |
| wb_data_o | output | 64 | PC value returned to the register pair |
| wb_valid_o | output | 1 | wb_data_o is valid this cycle |

## Verification
The bench sweeps every op code against all eight flag combinations and a set of offsets, including the most negative and most positive ones, zero and minus one. It runs these from start addresses near zero and near the top of the 48-bit space, so that backward branches and wrap-around are covered. A design that used the branch's own address would be off by 4 on every target and every read-back value. A design that zero-extended the offset would jump forward on negative offsets, and a carry into bit 48 would break the wrap cases. A swap that returned the new PC, or any write that kept the low two bits, would differ from the model on the first such operation. The bench also presents operations before launch and with the valid flag low, and expects the PC to hold.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [3:0] {
        OP_ADVANCE   = 4'd0,
        OP_JUMP      = 4'd1,
        OP_JMP_SCC1  = 4'd2,
        OP_JMP_SCC0  = 4'd3,
        OP_JMP_VCCZ1 = 4'd4,
        OP_JMP_VCCZ0 = 4'd5,
        OP_JMP_EXZ1  = 4'd6,
        OP_JMP_EXZ0  = 4'd7,
        OP_READ_PC   = 4'd8,
        OP_WRITE_PC  = 4'd9,
        OP_SWAP_PC   = 4'd10
    } pcu_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pcu_state_e;

endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
    import pcu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    input  logic op_valid_i,
    output logic run_o,
    output logic accept_o
);

    pcu_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch_i) state_d = ST_RUN;   // LAUNCH
            ST_RUN:  if (launch_i) state_d = ST_RUN;   // LAUNCH (relaunch)
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        run_o    = (state_q == ST_RUN);
        accept_o = 1'b0;
        unique case (state_q)
            ST_IDLE: accept_o = 1'b0;
            ST_RUN:  accept_o = op_valid_i && !launch_i;
            default: accept_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcu_cond_eval.sv
module pcu_cond_eval
    import pcu_pkg::*;
(
    input  logic [3:0] op_i,
    input  logic       scc_i,
    input  logic       vccz_i,
    input  logic       execz_i,
    output logic       is_jump_o,
    output logic       taken_o
);

    pcu_op_e op;
    assign op = pcu_op_e'(op_i);

    always_comb begin
        is_jump_o = 1'b1;
        taken_o   = 1'b0;
        unique case (op)
            OP_JUMP:      taken_o = 1'b1;
            OP_JMP_SCC1:  taken_o = scc_i;
            OP_JMP_SCC0:  taken_o = !scc_i;
            OP_JMP_VCCZ1: taken_o = vccz_i;
            OP_JMP_VCCZ0: taken_o = !vccz_i;
            OP_JMP_EXZ1:  taken_o = execz_i;
            OP_JMP_EXZ0:  taken_o = !execz_i;
            default: begin
                is_jump_o = 1'b0;
                taken_o   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pcu_target_calc.sv
module pcu_target_calc #(
    parameter int PC_W       = 48,
    parameter int IMM_W      = 16,
    parameter int INSN_BYTES = 4
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [PC_W-1:0]  next_o,
    output logic [PC_W-1:0]  target_o
);

    localparam int SHIFT = $clog2(INSN_BYTES);
    localparam int EXT_W = PC_W - IMM_W - SHIFT;

    logic [PC_W-1:0] offset;

    // sign-extend first, then scale to bytes
    assign offset   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, {SHIFT{1'b0}}};
    assign next_o   = pc_i + PC_W'(INSN_BYTES);
    assign target_o = next_o + offset;

endmodule

// File: rtl/wave_pc_unit.sv
module wave_pc_unit
    import pcu_pkg::*;
#(
    parameter int PC_W       = 48,
    parameter int IMM_W      = 16,
    parameter int DATA_W     = 64,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic [PC_W-1:0]   launch_pc_i,
    input  logic              op_valid_i,
    input  logic [3:0]        op_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] sgpr_pair_i,
    input  logic              scc_i,
    input  logic              vccz_i,
    input  logic              execz_i,
    output logic [PC_W-1:0]   fetch_pc_o,
    output logic [DATA_W-1:0] wb_data_o,
    output logic              wb_valid_o
);

    localparam int LOW_Z = $clog2(INSN_BYTES);

    logic            run_q;
    logic            accept;
    logic            is_jump, taken;
    logic [PC_W-1:0] pc_q, pc_d;
    logic [PC_W-1:0] seq_pc, jump_pc;
    logic [DATA_W-1:0] wb_d;
    logic            wbv_d;
    pcu_op_e         op;

    assign op = pcu_op_e'(op_i);

    pcu_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_i   (launch_i),
        .op_valid_i (op_valid_i),
        .run_o      (run_q),
        .accept_o   (accept)
    );

    pcu_cond_eval u_cond (
        .op_i      (op_i),
        .scc_i     (scc_i),
        .vccz_i    (vccz_i),
        .execz_i   (execz_i),
        .is_jump_o (is_jump),
        .taken_o   (taken)
    );

    pcu_target_calc #(
        .PC_W       (PC_W),
        .IMM_W      (IMM_W),
        .INSN_BYTES (INSN_BYTES)
    ) u_tgt (
        .pc_i     (pc_q),
        .imm_i    (imm_i),
        .next_o   (seq_pc),
        .target_o (jump_pc)
    );

    // next PC and write-back selection (R2..R9)
    always_comb begin
        pc_d  = pc_q;
        wb_d  = DATA_W'(seq_pc);
        wbv_d = 1'b0;
        if (launch_i) begin
            pc_d = launch_pc_i;
        end else if (accept) begin
            if (is_jump) begin
                pc_d = taken ? jump_pc : seq_pc;
            end else begin
                unique case (op)
                    OP_READ_PC: begin
                        pc_d  = seq_pc;
                        wbv_d = 1'b1;
                    end
                    OP_WRITE_PC: pc_d = sgpr_pair_i[PC_W-1:0];
                    OP_SWAP_PC: begin
                        pc_d  = sgpr_pair_i[PC_W-1:0];
                        wbv_d = 1'b1;
                    end
                    default: pc_d = seq_pc;
                endcase
            end
        end
        pc_d[LOW_Z-1:0] = '0;   // R10
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q       <= '0;
            wb_data_o  <= '0;
            wb_valid_o <= 1'b0;
        end else begin
            pc_q       <= pc_d;
            wb_data_o  <= wb_d;
            wb_valid_o <= wbv_d;
        end
    end

    assign fetch_pc_o = pc_q;

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
    parameter int PC_W   = 48,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_i,
    input logic              launch_i,
    input logic [PC_W-1:0]   launch_pc_i,
    input logic              op_valid_i,
    input logic [3:0]        op_i,
    input logic [PC_W-1:0]   fetch_pc_o,
    input logic [DATA_W-1:0] wb_data_o,
    input logic              wb_valid_o
);

    logic [PC_W-1:0] nxt;
    assign nxt = fetch_pc_o + PC_W'(4);

    a_r10_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_pc_o[1:0] == 2'b00);

    a_r2_launch_load: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |=> fetch_pc_o == {$past(launch_pc_i[PC_W-1:2]), 2'b00});

    a_r3_hold_no_op: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !launch_i && !op_valid_i) |=> ($stable(fetch_pc_o) && !wb_valid_o));

    a_r1_idle_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !launch_i) |=> ($stable(fetch_pc_o) && !wb_valid_o));

    a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !launch_i && op_valid_i && op_i == 4'd0) |=> fetch_pc_o == $past(nxt));

    a_r7_wb_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> wb_data_o == DATA_W'($past(nxt)));

    a_r8_write_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !launch_i && op_valid_i && op_i == 4'd9) |=> !wb_valid_o);

endmodule

bind wave_pc_unit pcu_checker #(.PC_W(PC_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_q),
    .launch_i    (launch_i),
    .launch_pc_i (launch_pc_i),
    .op_valid_i  (op_valid_i),
    .op_i        (op_i),
    .fetch_pc_o  (fetch_pc_o),
    .wb_data_o   (wb_data_o),
    .wb_valid_o  (wb_valid_o)
);

// File: tb/wave_pc_unit_tb_top.sv
`timescale 1ns/1ps
module wave_pc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        launch_i = 1'b0;
    logic [47:0] launch_pc_i = '0;
    logic        op_valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [15:0] imm_i = '0;
    logic [63:0] sgpr_pair_i = '0;
    logic        scc_i = 1'b0, vccz_i = 1'b0, execz_i = 1'b0;
    logic [47:0] fetch_pc_o;
    logic [63:0] wb_data_o;
    logic        wb_valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [47:0] m_pc = '0;
    logic [63:0] m_wb = '0;
    bit          m_wbv = 1'b0;
    bit          m_run = 1'b0;

    always #2.5 clk = ~clk;

    wave_pc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .launch_i(launch_i), .launch_pc_i(launch_pc_i),
        .op_valid_i(op_valid_i), .op_i(op_i), .imm_i(imm_i), .sgpr_pair_i(sgpr_pair_i),
        .scc_i(scc_i), .vccz_i(vccz_i), .execz_i(execz_i),
        .fetch_pc_o(fetch_pc_o), .wb_data_o(wb_data_o), .wb_valid_o(wb_valid_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pick_imm(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'hFFFF;
            3: return 16'h7FFF;
            4: return 16'h8000;
            default: return 16'hFFF3;
        endcase
    endfunction

    function automatic logic [47:0] pick_base(input int i);
        case (i % 4)
            0: return 48'h0000_0000_0010;
            1: return 48'hFFFF_FFFF_FFF8;
            2: return 48'h0000_8000_1234;
            default: return {$urandom(), $urandom()} ;
        endcase
    endfunction

    task automatic step(input bit l, input logic [47:0] lpc, input bit v,
                        input logic [3:0] op, input logic [15:0] imm,
                        input logic [63:0] pair, input logic [2:0] fl, input string tag);
        logic [47:0] nx, tg;
        bit tk;
        @(negedge clk);
        launch_i = l; launch_pc_i = lpc; op_valid_i = v; op_i = op; imm_i = imm;
        sgpr_pair_i = pair; scc_i = fl[0]; vccz_i = fl[1]; execz_i = fl[2];
        nx = m_pc + 48'd4;
        tg = nx + {{30{imm[15]}}, imm, 2'b00};
        m_wbv = 1'b0;
        if (l) begin
            m_pc = {lpc[47:2], 2'b00};
            m_run = 1'b1;
        end else if (m_run && v) begin
            case (op)
                4'd1: tk = 1'b1;
                4'd2: tk = fl[0];
                4'd3: tk = !fl[0];
                4'd4: tk = fl[1];
                4'd5: tk = !fl[1];
                4'd6: tk = fl[2];
                4'd7: tk = !fl[2];
                default: tk = 1'b0;
            endcase
            if (op == 4'd9 || op == 4'd10) m_pc = {pair[47:2], 2'b00};
            else if (tk) m_pc = tg;
            else m_pc = nx;
            if (op == 4'd8 || op == 4'd10) begin
                m_wbv = 1'b1;
                m_wb  = {16'h0, nx};
            end
        end
        @(posedge clk);
        #1;
        check(tag, 64'(fetch_pc_o), 64'(m_pc));
        check(tag, 64'(wb_valid_o), 64'(m_wbv));
        if (m_wbv) check(tag, wb_data_o, m_wb);
        check("R10", 64'(fetch_pc_o[1:0]), 64'd0);
    endtask

    function automatic string op_tag(input logic [3:0] op);
        if (op == 4'd0 || op > 4'd10) return "R4";
        if (op == 4'd1) return "R5";
        if (op <= 4'd7) return "R6";
        if (op == 4'd8) return "R7";
        if (op == 4'd9) return "R8";
        return "R9";
    endfunction

    initial begin
        #900000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", 64'(fetch_pc_o), 64'd0);
        check("R1", 64'(wb_valid_o), 64'd0);
        @(negedge clk) rst_n = 1'b1;
        // R1: operations before launch are dropped
        step(0, '0, 1, 4'd1, 16'h0040, '0, 3'd7, "R1");
        step(0, '0, 1, 4'd9, 64'h1234_5678, '0, 3'd0, "R1");
        step(0, '0, 1, 4'd8, '0, '0, 3'd0, "R1");
        // R2: launch clears low bits and beats an operation
        step(1, 48'h0000_0000_1003, 1, 4'd9, '0, 64'hABCD, 3'd0, "R2");
        // R3: no valid, PC holds
        step(0, '0, 0, 4'd1, 16'h0100, '0, 3'd7, "R3");
        step(0, '0, 0, 4'd8, '0, '0, 3'd0, "R3");
        // R4: wrap at the top of the address space
        step(1, 48'hFFFF_FFFF_FFFC, 0, '0, '0, '0, 3'd0, "R2");
        step(0, '0, 1, 4'd0, '0, '0, 3'd0, "R4");
        // sweep: every op, flag combination and offset
        for (int b = 0; b < 4; b++) begin
            for (int o = 0; o < 16; o++) begin
                for (int f = 0; f < 8; f++) begin
                    for (int i = 0; i < 6; i++) begin
                        logic [63:0] pr;
                        pr = {$urandom(), $urandom()};
                        step(1, pick_base(b), 0, '0, '0, '0, 3'd0, "R2");
                        step(0, '0, 1, 4'(o), pick_imm(i), pr, 3'(f), op_tag(4'(o)));
                        if (i == 0) step(0, '0, 0, 4'(o), 16'h0005, pr, 3'(f), "R3");
                    end
                end
            end
        end
        // back-to-back swap then read chain
        step(1, 48'h0000_0000_0200, 0, '0, '0, '0, 3'd0, "R2");
        step(0, '0, 1, 4'd10, '0, 64'hFFFF_0000_0000_0777, 3'd0, "R9");
        step(0, '0, 1, 4'd8, '0, '0, 3'd0, "R7");
        step(0, '0, 1, 4'd1, 16'hFFFE, '0, 3'd0, "R5");
        step(0, '0, 1, 4'd0, '0, '0, 3'd0, "R4");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule